// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Bus Interface

This block is the digital side of a 12-bit successive-approximation converter. A host starts a conversion with a rising chip-enable edge while select and the read/convert line are low. The block then runs a binary search, one result bit per clock, from the most significant bit down. The analog comparator's verdict arrives on a single input bit for each trial. A busy flag is high for exactly the span of the conversion. While that flag is high, further control activity cannot cut the conversion short or start it again.

The conversion length is picked by the byte-address input, which is captured when a conversion starts. Low gives a full 12-bit search. High gives a short 8-bit search, and the four low result bits are then zero. A second start edge during a conversion recaptures the byte-address input, so the running conversion can switch length part way.

Reading is governed by four pins together. The bus is driven only when select is active, read/convert is in read, chip-enable is high and the block is idle. The format and byte-address inputs then choose which lines carry which part of the result. The three-state bus is modelled as a data vector plus a per-bit output-enable vector. All pins are plain level signals, because there is no data stream with back-pressure here: a read is a combinational window opened and closed by the host.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, busy is low, every output enable is off, and the result register reads as zero.
- R2: A conversion starts when chip-enable is high at a clock edge and was low at the previous edge, with select_n low, rd_cnv low and busy low. Busy is high from the clock after that edge.
- R3: Busy stays high for exactly 12 clocks when addr_sel was low at the start, and for exactly 8 clocks when it was high.
- R4: The comparator bit sampled at the k-th busy clock decides result bit 11-k, with 1 keeping the bit. The result register changes only at the clock where busy falls, and holds its value until the next conversion ends.
- R5: After an 8-bit conversion, result bits 3..0 are zero.
- R6: A chip-enable rise with select_n high or with rd_cnv high starts nothing and leaves the result unchanged.
- R7: While busy, chip-enable, select_n and rd_cnv activity that keeps addr_sel unchanged neither ends nor restarts the conversion.
- R8: A start event during a conversion recaptures addr_sel. The new length applies from the decision after that edge. If the conversion is already past the new stop point, it ends at the next decision, and bits 3..0 are then zero when the new length is 8 bits.
- R9: The enable vector is non-zero only when rd_cnv is high, select_n is low, chip-enable is high and busy is low. It is all zero whenever busy is high.
- R10: With fmt_full high, a read enables all 12 lines, and line i carries result bit i.
- R11: With fmt_full low and addr_sel low, a read enables lines 11..4, which carry result bits 11..4.
- R12: With fmt_full low and addr_sel high, a read enables lines 11..4: lines 11..8 carry result bits 3..0 and lines 7..4 carry zero.
- R13: Any line whose enable is off has data 0. Lines 3..0 are never enabled while fmt_full is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; its rise is the start event, and high opens reads |
| select_n | input | 1 | Active-low chip select |
| rd_cnv | input | 1 | 1 = read, 0 = convert |
| addr_sel | input | 1 | Length select at start; byte select on read |
| fmt_full | input | 1 | 1 = whole word in one read, 0 = two 8-line reads |
| cmp_in | input | 1 | Comparator verdict for the current trial bit |
| busy | output | 1 | High only while a conversion runs |
| db_out | output | 12 | Data bus values |
| db_oe | output | 12 | Per-line output enable; off means high-impedance |

## Verification
The assertions assume that chip-enable, select_n and rd_cnv are synchronous to the clock and stable around its rising edge. They also assume that the comparator bit is valid at every busy clock. The bench therefore changes every input only at falling edges. It presents the comparator bit from a target code, highest bit first, one bit per busy clock. Read sweeps walk all 32 combinations of the five read-side pins within one half period, so no clock edge can see a transient start event in the middle of a sweep. Recapture tests keep addr_sel steady except on the one chosen start edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    RD_FULL = 2'd0,
    RD_HIGH = 2'd1,
    RD_LOW  = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/sar_start_ctl.sv
module sar_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic select_n,
  input  logic rd_cnv,
  input  logic addr_sel,
  input  logic done,
  output logic busy,
  output logic start,
  output logic short_len
);
  logic ce_q;
  logic start_evt;

  assign start_evt = ce & ~ce_q & ~select_n & ~rd_cnv;
  assign start     = start_evt & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b0;
      busy      <= 1'b0;
      short_len <= 1'b0;
    end else begin
      ce_q <= ce;
      if (start_evt) short_len <= addr_sel;
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ce && !select_n && !rd_cnv)); // R2
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              short_len,
  input  logic              cmp_in,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int NIB = DATA_W - SHORT_W;
  localparam int IW  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] LOW_MASK = {{SHORT_W{1'b0}}, {NIB{1'b1}}};
  localparam logic [DATA_W-1:0] TOP_BIT  = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] work, dec, nxt;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     stop_idx;

  assign stop_idx = short_len ? IW'(NIB) : '0;
  assign done     = busy && (idx <= stop_idx);

  always_comb begin
    dec      = work;
    dec[idx] = cmp_in;
    nxt      = dec;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= '0;
      idx    <= '0;
      result <= '0;
    end else if (start) begin
      work <= TOP_BIT;
      idx  <= IW'(DATA_W - 1);
    end else if (busy) begin
      if (done) begin
        result <= short_len ? (dec & ~LOW_MASK) : dec;
      end else begin
        work <= nxt;
        idx  <= idx - 1'b1;
      end
    end
  end

  AST_SHORT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (done && short_len) |=> (result[NIB-1:0] == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result)); // R4
endmodule

// File: rtl/sar_bus_drv.sv
module sar_bus_drv
  import sar_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              select_n,
  input  logic              rd_cnv,
  input  logic              busy,
  input  logic              fmt_full,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] db_out,
  output logic [DATA_W-1:0] db_oe
);
  localparam int NIB = DATA_W - SHORT_W;

  rd_mode_e mode;
  logic     rd_en;

  assign rd_en = rd_cnv & ~busy & ce & ~select_n;
  assign mode  = fmt_full ? RD_FULL : (addr_sel ? RD_LOW : RD_HIGH);

  always_comb begin
    db_out = '0;
    db_oe  = '0;
    if (rd_en) begin
      unique case (mode)
        RD_FULL: begin
          db_oe  = '1;
          db_out = result;
        end
        RD_HIGH: begin
          db_oe[DATA_W-1:NIB]  = '1;
          db_out[DATA_W-1:NIB] = result[DATA_W-1:NIB];
        end
        RD_LOW: begin
          db_oe[DATA_W-1:NIB]    = '1;
          db_out[DATA_W-1 -: NIB] = result[NIB-1:0];
        end
        default: begin
          db_oe  = '0;
          db_out = '0;
        end
      endcase
    end
  end

  AST_LSB_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_full |-> (db_oe[NIB-1:0] == '0)); // R13
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int DATA_W  = 12,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              select_n,
  input  logic              rd_cnv,
  input  logic              addr_sel,
  input  logic              fmt_full,
  input  logic              cmp_in,
  output logic              busy,
  output logic [DATA_W-1:0] db_out,
  output logic [DATA_W-1:0] db_oe
);
  logic              start, short_len, done;
  logic [DATA_W-1:0] result;

  sar_start_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .select_n  (select_n),
    .rd_cnv    (rd_cnv),
    .addr_sel  (addr_sel),
    .done      (done),
    .busy      (busy),
    .start     (start),
    .short_len (short_len)
  );

  sar_core #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .short_len (short_len),
    .cmp_in    (cmp_in),
    .done      (done),
    .result    (result)
  );

  sar_bus_drv #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .select_n (select_n),
    .rd_cnv   (rd_cnv),
    .busy     (busy),
    .fmt_full (fmt_full),
    .addr_sel (addr_sel),
    .result   (result),
    .db_out   (db_out),
    .db_oe    (db_oe)
  );

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (db_oe == '0)); // R9
endmodule

// File: tb/test_sar_bus_ctrl.sv
module test_sar_bus_ctrl;
  localparam int CLK_PERIOD = 100;
  localparam int W   = 12;
  localparam int NIB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, select_n = 1'b1, rd_cnv = 1'b1, addr_sel = 1'b0;
  logic fmt_full = 1'b1, cmp_in = 1'b0;
  logic busy;
  logic [W-1:0] db_out, db_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_bus_ctrl i_sar_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .select_n(select_n), .rd_cnv(rd_cnv),
    .addr_sel(addr_sel), .fmt_full(fmt_full), .cmp_in(cmp_in),
    .busy(busy), .db_out(db_out), .db_oe(db_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // All 32 read-side pin combinations inside one half period (no edge in between).
  task automatic read_sweep(input logic [W-1:0] res, input string tag);
    logic [W-1:0] eo, ed;
    @(negedge clk);
    for (int m = 0; m < 32; m++) begin
      fmt_full = m[0]; addr_sel = m[1]; ce = m[2]; select_n = m[3]; rd_cnv = m[4];
      #1;
      eo = '0; ed = '0;
      if (m[4] && m[2] && !m[3]) begin
        if (m[0]) begin eo = 12'hFFF; ed = res; end            // R10
        else if (!m[1]) begin eo = 12'hFF0; ed = res & 12'hFF0; end // R11
        else begin eo = 12'hFF0; ed = {res[3:0], 8'h00}; end   // R12
      end
      chk(db_oe == eo, {tag, " R9 enable"}, db_oe, eo);
      chk(db_out == ed, {tag, " R13/R10/R11/R12 data"}, db_out, ed);
    end
    ce = 1'b0; select_n = 1'b1; rd_cnv = 1'b1; fmt_full = 1'b1; addr_sel = 1'b0;
  endtask

  // Runs one conversion; rl_at = decision index whose edge sees a new start event (-1: none).
  task automatic run_conv(input logic [W-1:0] tgt, input logic ao0, input int rl_at,
                          input logic ao1, input bit tog, input string tag);
    int exp_len, cnt, kk;
    bit sh, fsh;
    logic [W-1:0] exp_res;
    sh = ao0; exp_len = 0; fsh = ao0;
    for (int k = 0; k < W; k++) begin
      if ((W - 1 - k) <= (sh ? NIB : 0)) begin exp_len = k + 1; fsh = sh; break; end
      if (k == rl_at) sh = ao1;
    end
    exp_res = fsh ? (tgt & 12'hFF0) : tgt;
    @(negedge clk);
    select_n = 1'b0; rd_cnv = 1'b0; ce = 1'b0; addr_sel = ao0; fmt_full = 1'b1;
    @(negedge clk);
    ce = 1'b1;
    cnt = 0; kk = 0;
    for (int g = 0; g < 20; g++) begin
      @(negedge clk);
      if (g == 0) chk(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
      if (!busy) break;
      cnt++;
      if (tog) begin
        chk(db_oe == '0, {tag, " R9 quiet while busy"}, db_oe, 0);
        ce = ~ce; rd_cnv = kk[1]; select_n = kk[2] & kk[0];
      end
      if (rl_at >= 1 && kk == rl_at - 1) ce = 1'b0;
      if (rl_at >= 1 && kk == rl_at) begin ce = 1'b1; addr_sel = ao1; end
      cmp_in = tgt[W - 1 - kk];
      kk++;
    end
    chk(cnt == exp_len, {tag, " R3/R7/R8 busy length"}, cnt, exp_len);
    rd_cnv = 1'b1; select_n = 1'b0; ce = 1'b1; fmt_full = 1'b1;
    #1;
    chk(db_out == exp_res && db_oe == 12'hFFF, {tag, " R4/R5 result"}, db_out, exp_res);
    ce = 1'b0; select_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    logic [W-1:0] last_res, t;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && db_oe == '0, "R1 in reset", {busy, db_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && db_oe == '0, "R1 after reset", {busy, db_oe}, 0);
    read_sweep(12'h000, "R1 zero result");

    run_conv(12'hA5A, 1'b0, -1, 1'b0, 0, "full A5A");
    read_sweep(12'hA5A, "sweep A5A");
    run_conv(12'h5A5, 1'b1, -1, 1'b1, 0, "short 5A5");
    read_sweep(12'h5A0, "sweep 5A0");
    run_conv(12'hFFF, 1'b0, -1, 1'b0, 0, "full FFF");
    run_conv(12'h000, 1'b0, -1, 1'b0, 0, "full 000");
    run_conv(12'h001, 1'b0, -1, 1'b0, 0, "full 001");
    run_conv(12'h800, 1'b1, -1, 1'b1, 0, "short 800");
    for (int i = 0; i < 40; i++) begin
      t = 12'((i * 1237 + 291) & 12'hFFF);
      run_conv(t, i[0], -1, i[0], 0, "sweep conv");
      if (i % 8 == 0) read_sweep(i[0] ? (t & 12'hFF0) : t, "sweep read");
    end

    run_conv(12'h9C3, 1'b0, -1, 1'b0, 1, "R7 toggle full");
    run_conv(12'h3E7, 1'b1, -1, 1'b1, 1, "R7 toggle short");

    run_conv(12'hB6D, 1'b0, 2, 1'b1, 0, "R8 full->short early");
    run_conv(12'hB6D, 1'b1, 2, 1'b0, 0, "R8 short->full");
    run_conv(12'h4D9, 1'b0, 6, 1'b1, 0, "R8 full->short mid");
    run_conv(12'h7AB, 1'b0, 8, 1'b1, 0, "R8 full->short late");
    last_res = 12'h7A0;

    // R6: rises without a valid start
    @(negedge clk); ce = 1'b0; select_n = 1'b1; rd_cnv = 1'b0;
    @(negedge clk); ce = 1'b1;
    @(negedge clk); chk(busy == 1'b0, "R6 select high", busy, 0);
    ce = 1'b0; select_n = 1'b0; rd_cnv = 1'b1;
    @(negedge clk); ce = 1'b1;
    @(negedge clk); chk(busy == 1'b0, "R6 read high", busy, 0);
    @(negedge clk); chk(busy == 1'b0, "R6 still idle", busy, 0);
    read_sweep(last_res, "R6 result kept");

    finish_run();
  end
endmodule